// File: doc/BRIEF.md
# Disk Controller Host Data Port

This block is the host-facing byte port of a floppy-style disk controller. One byte-wide data path carries command parameter bytes from the host, sector data in either direction, and result status bytes back to the host. Two status flags tell the host when it may move a byte and in which direction: a request-for-master flag (`msr_rqm`) and a direction flag (`msr_dio`). On the other side, the controller core moves bytes through a single strobe (`core_stb`). That core may be the command decoder, the disk serializer or the status generator, depending on the phase.

After reset, and in every command phase, the port holds at most one byte. A configuration load can turn on a 16-byte FIFO with a service threshold. The FIFO only takes effect in the execution phase, and it is emptied on entry to that phase. During execution, `svc_req` asks the DMA or host to service the port. If the core finds no byte to send to the disk, that is an underrun: the command ends, the rest of the sector is fed with zero bytes, and a CRC-valid request is issued at the sector end. If the disk delivers a byte into a full FIFO, that is an overrun: the command ends, and `done` waits until the host has emptied the FIFO.

The threshold trades host latency for bus activity. The time the host has to answer a request is threshold × 8 / data rate, less 1.5 µs. For example, at 1 Mbps with 8 bytes this gives 62.5 µs.

Top module: `fdc_data_port`

## Requirements
- R1: After reset the port is in the command phase with one byte of storage: `msr_rqm`=1, `msr_dio`=0, `svc_req`=0, `done`=0, `crc_req`=0, `overrun`=0, `underrun`=0. The FIFO stays disabled until a configuration load.
- R2: In the command phase, one host write fills the port and `msr_rqm` goes to 0. A further host write is ignored. A core strobe returns the stored byte on `core_rdata` and sets `msr_rqm` back to 1.
- R3: In the result phase, `msr_dio`=1. A core strobe stores a status byte and sets `msr_rqm`=1. A second core strobe while a byte is held is ignored. A host read returns the held byte.
- R4: An `exec_start` pulse empties the storage. With `exec_rd`=0 the next state is `msr_rqm`=1, `msr_dio`=0. With `exec_rd`=1 it is `msr_rqm`=0, `msr_dio`=1.
- R5: With the FIFO enabled, a host-writing execution phase accepts 16 bytes and then drops `msr_rqm`. The core receives the bytes in the order written.
- R6: With the FIFO enabled and the host writing, `svc_req` is 1 exactly when the free space (16 minus the byte count) is at least the threshold.
- R7: With the FIFO enabled and the host reading, `svc_req` is 1 exactly when the byte count is at least the threshold. A threshold value of 0 acts as 1.
- R8: With the FIFO disabled, the execution phase holds one byte and `svc_req` equals `msr_rqm`.
- R9: A core strobe with an empty port during a host-writing execution is an underrun. `underrun` rises, `msr_rqm` stays 0, and `core_rdata` is 0x00 for every strobe until `sector_len` strobes in total have been counted.
- R10: At the edge of the `sector_len`-th core strobe of a host-writing execution, `done` and `crc_req` go high for one cycle. The port then enters the result phase, empty, with `msr_dio`=1.
- R11: A core strobe with a full port during a host-reading execution is an overrun. The byte is dropped and `overrun` rises. The held bytes stay readable in order. `done` is held off until the port is empty.
- R12: After the `sector_len`-th byte of a host-reading execution, or after an overrun, the port drains. `svc_req` equals "not empty". `done` pulses one cycle after the last byte is read, with `crc_req`=0.
- R13: A `cmd_start` pulse returns to the single-byte command phase even when the FIFO is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load FIFO enable and threshold |
| cfg_fifo_en | input | 1 | FIFO enable value for the load |
| cfg_thresh | input | 4 | Service threshold for the load (0 acts as 1) |
| cmd_start | input | 1 | Pulse: begin a command phase |
| exec_start | input | 1 | Pulse: begin the execution phase |
| exec_rd | input | 1 | Execution direction, 1 = host reads disk data |
| sector_len | input | 12 | Bytes in the current sector (at least 1) |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte at the head of the port for the host |
| msr_rqm | output | 1 | Host may transfer a byte |
| msr_dio | output | 1 | 1 = host must read, 0 = host must write |
| svc_req | output | 1 | Service request during execution |
| core_stb | input | 1 | Core byte strobe (take or give one byte) |
| core_wdata | input | 8 | Byte supplied by the core |
| core_rdata | output | 8 | Byte offered to the core (0x00 when empty or filling) |
| done | output | 1 | One-cycle pulse: execution finished, result phase entered |
| crc_req | output | 1 | One-cycle pulse: append a valid CRC to the written sector |
| overrun | output | 1 | Sticky overrun flag for the current command |
| underrun | output | 1 | Sticky underrun flag for the current command |

## Verification
The assertions rely on a few conditions on the inputs:
- `sector_len` is at least 1.
- `cmd_start` and `exec_start` are never raised in the same cycle.
- The threshold never reaches the FIFO depth, which the 4-bit width guarantees.

Under these conditions, a service request always implies `msr_rqm` and the single-byte phases never hold more than one byte. The random runs respect the same limits. They pick a threshold from 1 to 15 and only strobe the core when the bench's own byte model says data or space is there. Underrun and overrun therefore occur only in the directed cases built to cause them.

// File: rtl/fdc_dp_pkg.sv
// Shared types for the disk controller host data port.
package fdc_dp_pkg;
    // Phase of the current command as seen by the data port.
    typedef enum logic [2:0] {
        PH_CMD    = 3'd0,
        PH_EXEC   = 3'd1,
        PH_ZFILL  = 3'd2,
        PH_DRAIN  = 3'd3,
        PH_RESULT = 3'd4
    } dp_phase_t;
endpackage

// File: rtl/fdc_dp_fifo.sv
// Byte store of the data port: a circular buffer with a count and a flush.
// Assumes the caller never pushes when full or pops when empty.
module fdc_dp_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy update, flush empties the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign rdata = mem[rd_ptr];
endmodule

// File: rtl/fdc_dp_flow.sv
// Combinational handshake logic: status flags, service request and the
// push/pop decisions for both ends. Assumes thresh is already at least 1.
module fdc_dp_flow
    import fdc_dp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int TW   = $clog2(DEPTH)
) (
    input  dp_phase_t     phase,
    input  logic          dir_rd,
    input  logic          fifo_mode,
    input  logic [TW-1:0] thresh,
    input  logic [CW-1:0] count,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic          core_stb,
    output logic          rqm,
    output logic          dio,
    output logic          svc,
    output logic          core_acc,
    output logic          core_err,
    output logic          push,
    output logic          pop
);
    logic [CW-1:0] cap;
    logic [CW-1:0] free_sp;
    logic          full, empty, host_acc;

    // Capacity, fill state and per-phase flags.
    always_comb begin
        cap      = (fifo_mode && phase == PH_EXEC) ? CW'(DEPTH) : CW'(1);
        full     = (count >= cap);
        empty    = (count == '0);
        free_sp  = CW'(DEPTH) - count;
        rqm      = 1'b0;
        dio      = 1'b0;
        svc      = 1'b0;
        core_acc = 1'b0;
        core_err = 1'b0;
        case (phase)
            PH_CMD: begin
                rqm      = !full;
                core_acc = core_stb && !empty;
            end
            PH_RESULT: begin
                dio      = 1'b1;
                rqm      = !empty;
                core_acc = core_stb && !full;
            end
            PH_EXEC: begin
                dio = dir_rd;
                if (dir_rd) begin
                    rqm      = !empty;
                    core_acc = core_stb && !full;
                    core_err = core_stb && full;
                end else begin
                    rqm      = !full;
                    core_acc = core_stb && !empty;
                    core_err = core_stb && empty;
                end
                if (fifo_mode)
                    svc = dir_rd ? (count >= CW'(thresh)) : (free_sp >= CW'(thresh));
                else
                    svc = rqm;
            end
            PH_DRAIN: begin
                dio = 1'b1;
                rqm = !empty;
                svc = !empty;
            end
            default: ;
        endcase
    end

    // Host transfers only under RQM; direction picks which end pushes.
    assign host_acc = rqm && (dio ? host_rd : host_wr);
    assign push     = dio ? core_acc : host_acc;
    assign pop      = dio ? host_acc : core_acc;
endmodule

// File: rtl/fdc_dp_seq.sv
// Phase sequencer: configuration, sector byte counting, error flags and the
// end-of-execution pulses. Assumes sector_len >= 1 and at most one of
// cmd_start / exec_start per cycle.
module fdc_dp_seq
    import fdc_dp_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int SECW  = 12,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int TW   = $clog2(DEPTH),
    localparam int SW1  = SECW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_load,
    input  logic            cfg_fifo_en,
    input  logic [TW-1:0]   cfg_thresh,
    input  logic            cmd_start,
    input  logic            exec_start,
    input  logic            exec_rd,
    input  logic [SECW-1:0] sector_len,
    input  logic            core_stb,
    input  logic            core_acc,
    input  logic            core_err,
    input  logic [CW-1:0]   fifo_cnt,
    output dp_phase_t       phase,
    output logic            dir_rd,
    output logic            fifo_mode,
    output logic [TW-1:0]   thresh,
    output logic            flush,
    output logic            done,
    output logic            crc_req,
    output logic            overrun,
    output logic            underrun
);
    logic [SECW-1:0] sec_cnt;
    logic [TW-1:0]   th_q;
    logic            beat, last_beat, wr_end, starting;

    // Configuration register, bypass mode after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_mode <= 1'b0;
            th_q      <= TW'(1);
        end else if (cfg_load) begin
            fifo_mode <= cfg_fifo_en;
            th_q      <= cfg_thresh;
        end
    end

    assign thresh    = (th_q == '0) ? TW'(1) : th_q;
    assign starting  = cmd_start || exec_start;
    assign beat      = (phase == PH_EXEC && (core_acc || core_err)) ||
                       (phase == PH_ZFILL && core_stb);
    assign last_beat = beat && ((SW1'(sec_cnt) + 1'b1) == SW1'(sector_len));
    assign wr_end    = !starting && !dir_rd && last_beat;
    assign flush     = starting || wr_end;

    // Phase transitions, sector count, sticky flags and end pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_CMD;
            dir_rd   <= 1'b0;
            sec_cnt  <= '0;
            overrun  <= 1'b0;
            underrun <= 1'b0;
            done     <= 1'b0;
            crc_req  <= 1'b0;
        end else begin
            done    <= 1'b0;
            crc_req <= 1'b0;
            if (cmd_start) begin
                phase    <= PH_CMD;
                overrun  <= 1'b0;
                underrun <= 1'b0;
            end else if (exec_start) begin
                phase    <= PH_EXEC;
                dir_rd   <= exec_rd;
                sec_cnt  <= '0;
                overrun  <= 1'b0;
                underrun <= 1'b0;
            end else begin
                if (beat) sec_cnt <= sec_cnt + 1'b1;
                case (phase)
                    PH_EXEC: begin
                        if (core_err && dir_rd) begin
                            overrun <= 1'b1;
                            phase   <= PH_DRAIN;
                        end else if (core_err) begin
                            underrun <= 1'b1;
                            phase    <= last_beat ? PH_RESULT : PH_ZFILL;
                            done     <= last_beat;
                            crc_req  <= last_beat;
                        end else if (last_beat) begin
                            if (dir_rd) begin
                                phase <= PH_DRAIN;
                            end else begin
                                phase   <= PH_RESULT;
                                done    <= 1'b1;
                                crc_req <= 1'b1;
                            end
                        end
                    end
                    PH_ZFILL: begin
                        if (last_beat) begin
                            phase   <= PH_RESULT;
                            done    <= 1'b1;
                            crc_req <= 1'b1;
                        end
                    end
                    PH_DRAIN: begin
                        if (fifo_cnt == '0) begin
                            phase <= PH_RESULT;
                            done  <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/fdc_data_port.sv
// Host data port of a disk controller: single-byte register in command and
// result phases, optional FIFO with service threshold during execution,
// underrun zero fill and overrun drain. Synchronous active-low reset.
module fdc_data_port
    import fdc_dp_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int SECW  = 12,
    localparam int TW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_load,
    input  logic            cfg_fifo_en,
    input  logic [TW-1:0]   cfg_thresh,
    input  logic            cmd_start,
    input  logic            exec_start,
    input  logic            exec_rd,
    input  logic [SECW-1:0] sector_len,
    input  logic            host_wr,
    input  logic            host_rd,
    input  logic [DW-1:0]   host_wdata,
    output logic [DW-1:0]   host_rdata,
    output logic            msr_rqm,
    output logic            msr_dio,
    output logic            svc_req,
    input  logic            core_stb,
    input  logic [DW-1:0]   core_wdata,
    output logic [DW-1:0]   core_rdata,
    output logic            done,
    output logic            crc_req,
    output logic            overrun,
    output logic            underrun
);
    localparam int CW = $clog2(DEPTH + 1);

    dp_phase_t     phase;
    logic          dir_rd, fifo_mode, flush, core_acc, core_err, push, pop;
    logic [TW-1:0] thresh;
    logic [CW-1:0] fifo_cnt;
    logic [DW-1:0] fifo_rdata, push_data;

    fdc_dp_seq #(.DEPTH(DEPTH), .SECW(SECW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_load(cfg_load), .cfg_fifo_en(cfg_fifo_en), .cfg_thresh(cfg_thresh),
        .cmd_start(cmd_start), .exec_start(exec_start), .exec_rd(exec_rd),
        .sector_len(sector_len), .core_stb(core_stb),
        .core_acc(core_acc), .core_err(core_err), .fifo_cnt(fifo_cnt),
        .phase(phase), .dir_rd(dir_rd), .fifo_mode(fifo_mode), .thresh(thresh),
        .flush(flush), .done(done), .crc_req(crc_req),
        .overrun(overrun), .underrun(underrun)
    );

    fdc_dp_flow #(.DEPTH(DEPTH)) u_flow (
        .phase(phase), .dir_rd(dir_rd), .fifo_mode(fifo_mode), .thresh(thresh),
        .count(fifo_cnt), .host_wr(host_wr), .host_rd(host_rd), .core_stb(core_stb),
        .rqm(msr_rqm), .dio(msr_dio), .svc(svc_req),
        .core_acc(core_acc), .core_err(core_err), .push(push), .pop(pop)
    );

    // The filling end depends on direction: core in read phases, host otherwise.
    assign push_data = msr_dio ? core_wdata : host_wdata;

    fdc_dp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(push), .pop(pop), .wdata(push_data),
        .rdata(fifo_rdata), .count(fifo_cnt)
    );

    assign host_rdata = fifo_rdata;
    // Zero bytes go to the disk while filling or when nothing is held.
    assign core_rdata = (phase == PH_ZFILL || fifo_cnt == '0) ? '0 : fifo_rdata;
endmodule

// File: rtl/fdc_dp_chk.sv
// Checker for the data port, bound into every instance of the top module.
module fdc_dp_chk
    import fdc_dp_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          exec_start,
    input logic          done,
    input logic          crc_req,
    input logic          msr_rqm,
    input logic          msr_dio,
    input logic          svc_req,
    input logic [DW-1:0] core_rdata,
    input dp_phase_t     phase,
    input logic [CW-1:0] fifo_cnt
);
    // R5: occupancy never exceeds the depth.
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH));

    // R2 / R13: command and result phases hold one byte at most.
    assert_single_byte_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CMD || phase == PH_RESULT) |-> fifo_cnt <= CW'(1));

    // R4: execution always starts empty.
    assert_exec_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exec_start |=> fifo_cnt == '0);

    // R6: a service request is only raised when a transfer is allowed.
    assert_svc_has_rqm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> msr_rqm);

    // R9: zero fill offers 0x00 and locks the host out.
    assert_zero_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ZFILL) |-> (core_rdata == '0 && !msr_rqm && !svc_req));

    // R10: a CRC request only comes with the end pulse.
    assert_crc_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        crc_req |-> done);

    // R12: the end pulse lands in the result phase with the port empty.
    assert_done_result_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (msr_dio && phase == PH_RESULT && fifo_cnt == '0));
endmodule

bind fdc_data_port fdc_dp_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .exec_start(exec_start), .done(done),
    .crc_req(crc_req), .msr_rqm(msr_rqm), .msr_dio(msr_dio), .svc_req(svc_req),
    .core_rdata(core_rdata), .phase(phase), .fifo_cnt(fifo_cnt)
);

// File: tb/fdc_data_port_tb.sv
`timescale 1ns/1ps
module fdc_data_port_tb;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 0, cfg_fifo_en = 0;
    logic [3:0]  cfg_thresh = 0;
    logic        cmd_start = 0, exec_start = 0, exec_rd = 0;
    logic [11:0] sector_len = 12'd1;
    logic        host_wr = 0, host_rd = 0;
    logic [7:0]  host_wdata = 0, core_wdata = 0;
    logic        core_stb = 0;
    logic [7:0]  host_rdata, core_rdata;
    logic        msr_rqm, msr_dio, svc_req, done, crc_req, overrun, underrun;

    int n_chk = 0;
    int n_bad = 0;

    fdc_data_port u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_fifo_en(cfg_fifo_en),
        .cfg_thresh(cfg_thresh), .cmd_start(cmd_start), .exec_start(exec_start),
        .exec_rd(exec_rd), .sector_len(sector_len), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .msr_rqm(msr_rqm), .msr_dio(msr_dio), .svc_req(svc_req),
        .core_stb(core_stb), .core_wdata(core_wdata), .core_rdata(core_rdata),
        .done(done), .crc_req(crc_req), .overrun(overrun), .underrun(underrun)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_svc_wr(input int cnt, input int th);
        return ((DEPTH - cnt) >= th) ? 1 : 0;
    endfunction

    function automatic int exp_svc_rd(input int cnt, input int th, input bit drain);
        if (drain) return (cnt > 0) ? 1 : 0;
        return (cnt >= th) ? 1 : 0;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic host_write(input logic [7:0] b);
        host_wr = 1'b1; host_wdata = b; cyc(); host_wr = 1'b0;
    endtask

    task automatic host_read(output logic [7:0] b);
        host_rd = 1'b1; b = host_rdata; cyc(); host_rd = 1'b0;
    endtask

    task automatic core_pop(output logic [7:0] b);
        core_stb = 1'b1; b = core_rdata; cyc(); core_stb = 1'b0;
    endtask

    task automatic core_push(input logic [7:0] b);
        core_stb = 1'b1; core_wdata = b; cyc(); core_stb = 1'b0;
    endtask

    task automatic start_cmd();
        cmd_start = 1'b1; cyc(); cmd_start = 1'b0;
    endtask

    task automatic start_exec(input logic rd, input int len);
        exec_rd = rd; sector_len = 12'(len); exec_start = 1'b1; cyc(); exec_start = 1'b0;
    endtask

    task automatic load_cfg(input logic en, input int th);
        cfg_fifo_en = en; cfg_thresh = 4'(th); cfg_load = 1'b1; cyc(); cfg_load = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; repeat (4) cyc(); rst_n = 1'b1;
    endtask

    // Random host-writing run against a byte model.
    task automatic rand_write(input int th, input int len);
        logic [7:0] mq[$];
        int pops = 0;
        logic [7:0] b;
        bit hw, cs;
        load_cfg(1'b1, th);
        start_cmd();
        start_exec(1'b0, len);
        while (pops < len) begin
            chk("R5 rqm random write", msr_rqm, (mq.size() < DEPTH) ? 1 : 0);
            chk("R6 svc random write", svc_req, exp_svc_wr(mq.size(), th));
            hw = (mq.size() < DEPTH) && ($urandom % 2 == 0);
            cs = (mq.size() > 0) && ($urandom % 2 == 0);
            b = 8'($urandom);
            if (cs) chk("R5 order random write", core_rdata, mq[0]);
            host_wr = hw; host_wdata = b; core_stb = cs;
            cyc();
            host_wr = 1'b0; core_stb = 1'b0;
            if (cs) begin void'(mq.pop_front()); pops++; end
            if (hw) mq.push_back(b);
        end
        chk("R10 done random write", done, 1);
        chk("R10 crc random write", crc_req, 1);
    endtask

    // Random host-reading run against a byte model.
    task automatic rand_read(input int th, input int len);
        logic [7:0] mq[$];
        int pushed = 0;
        bit drain = 1'b0;
        logic [7:0] b;
        bit hr, cs;
        load_cfg(1'b1, th);
        start_cmd();
        start_exec(1'b1, len);
        while (!(drain && mq.size() == 0)) begin
            chk("R7 rqm random read", msr_rqm, (mq.size() > 0) ? 1 : 0);
            chk("R7 svc random read", svc_req, exp_svc_rd(mq.size(), th, drain));
            cs = !drain && (mq.size() < DEPTH) && ($urandom % 2 == 0);
            hr = (mq.size() > 0) && ($urandom % 2 == 0);
            b = 8'($urandom);
            if (hr) chk("R7 order random read", host_rdata, mq[0]);
            host_rd = hr; core_stb = cs; core_wdata = b;
            cyc();
            host_rd = 1'b0; core_stb = 1'b0;
            if (hr) void'(mq.pop_front());
            if (cs) begin mq.push_back(b); pushed++; end
            if (pushed == len) drain = 1'b1;
        end
        chk("R12 no early done", done, 0);
        cyc();
        chk("R12 done random read", done, 1);
        chk("R12 no crc on read", crc_req, 0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] b;
        void'($urandom(32'd20250611));
        do_reset();

        // R1 reset state
        chk("R1 rqm", msr_rqm, 1);
        chk("R1 dio", msr_dio, 0);
        chk("R1 svc", svc_req, 0);
        chk("R1 done", done, 0);
        chk("R1 crc", crc_req, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 underrun", underrun, 0);

        // R2 single-byte command phase
        host_write(8'hA5);
        chk("R2 rqm after write", msr_rqm, 0);
        host_write(8'h3C);
        core_pop(b);
        chk("R2 core byte", b, 8'hA5);
        chk("R2 rqm after pop", msr_rqm, 1);
        host_write(8'h77);
        core_pop(b);
        chk("R2 second byte", b, 8'h77);

        // R8 bypass execution write, R10 end pulses
        start_exec(1'b0, 3);
        chk("R4 rqm write exec", msr_rqm, 1);
        chk("R4 dio write exec", msr_dio, 0);
        chk("R8 svc equals rqm", svc_req, 1);
        host_write(8'h11);
        chk("R8 bypass full", msr_rqm, 0);
        chk("R8 svc off", svc_req, 0);
        core_pop(b); chk("R8 byte 1", b, 8'h11);
        host_write(8'h22); core_pop(b); chk("R8 byte 2", b, 8'h22);
        host_write(8'h33); core_pop(b); chk("R8 byte 3", b, 8'h33);
        chk("R10 done", done, 1);
        chk("R10 crc", crc_req, 1);
        chk("R10 dio result", msr_dio, 1);
        chk("R10 result empty", msr_rqm, 0);
        cyc();
        chk("R10 done one cycle", done, 0);

        // R3 result phase single byte
        core_push(8'hC1);
        chk("R3 rqm", msr_rqm, 1);
        chk("R3 dio", msr_dio, 1);
        core_push(8'hC2);
        host_read(b);
        chk("R3 status byte", b, 8'hC1);
        chk("R3 empty after read", msr_rqm, 0);

        // R4 flush on execution entry
        start_cmd();
        host_write(8'h55);
        start_exec(1'b1, 5);
        chk("R4 rqm read exec flushed", msr_rqm, 0);
        chk("R4 dio read exec", msr_dio, 1);

        // R13 command phase stays single byte with FIFO enabled
        load_cfg(1'b1, 4);
        start_cmd();
        host_write(8'h01);
        chk("R13 single byte", msr_rqm, 0);

        // R5/R6 FIFO write fill, R9 underrun zero fill
        start_exec(1'b0, 20);
        for (int i = 0; i < DEPTH; i++) begin
            host_write(8'(8'h40 + i));
            chk("R5 rqm while filling", msr_rqm, (i < DEPTH - 1) ? 1 : 0);
            chk("R6 svc while filling", svc_req, exp_svc_wr(i + 1, 4));
        end
        host_write(8'hEE);
        for (int i = 0; i < DEPTH; i++) begin
            core_pop(b);
            chk("R5 order", b, 8'h40 + i);
        end
        chk("R9 no underrun yet", underrun, 0);
        core_pop(b);
        chk("R9 zero at underrun", b, 0);
        chk("R9 underrun flag", underrun, 1);
        chk("R9 rqm held low", msr_rqm, 0);
        host_write(8'h99);
        for (int i = 0; i < 3; i++) begin
            chk("R10 no done during fill", done, 0);
            core_pop(b);
            chk("R9 zero fill byte", b, 0);
        end
        chk("R10 done after fill", done, 1);
        chk("R10 crc after fill", crc_req, 1);

        // R11 overrun, R7 read threshold
        start_cmd();
        start_exec(1'b1, 100);
        for (int i = 0; i < DEPTH; i++) begin
            core_push(8'(8'h80 + i));
            chk("R7 svc threshold", svc_req, (i + 1 >= 4) ? 1 : 0);
        end
        core_push(8'hFF);
        chk("R11 overrun flag", overrun, 1);
        chk("R11 rqm", msr_rqm, 1);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R11 no early done", done, 0);
            host_read(b);
            chk("R11 order", b, 8'h80 + i);
        end
        chk("R12 done wait", done, 0);
        cyc();
        chk("R12 done after drain", done, 1);
        chk("R12 no crc", crc_req, 0);

        // R7 threshold zero acts as one, R12 normal read end
        load_cfg(1'b1, 0);
        start_cmd();
        start_exec(1'b1, 2);
        chk("R7 svc empty", svc_req, 0);
        core_push(8'h5A);
        chk("R7 svc at one byte", svc_req, 1);
        core_push(8'hA5);
        chk("R12 drain svc", svc_req, 1);
        host_read(b); chk("R12 byte 1", b, 8'h5A);
        host_read(b); chk("R12 byte 2", b, 8'hA5);
        chk("R12 not yet done", done, 0);
        cyc();
        chk("R12 done", done, 1);

        // Random runs
        for (int k = 0; k < 4; k++) begin
            rand_write(1 + int'($urandom % 15), 60);
            rand_read(1 + int'($urandom % 15), 60);
        end

        // R1 reset returns to bypass mode
        do_reset();
        start_exec(1'b0, 4);
        host_write(8'h10);
        chk("R1 bypass after reset", msr_rqm, 0);

        summary();
        $finish;
    end
endmodule